// File: doc/BRIEF.md
# Multicore Coherency Unit Register Bank

This block is the software-visible register file for the snoop control logic of a small cluster of one to four processors. It answers a simple 32-bit APB-style register bus and decodes a 256-byte window. Only the register-level behaviour is modelled. Snooping, tag storage, address filtering, cache invalidation and security gating are not built. Their registers either read as zero or, for invalidation, raise a one-cycle pulse for an external cache to act on.

Software sees four things:
- a one-bit enable;
- a read-only word that describes how many processors are present;
- a 32-bit power status word, with one byte lane per processor, written through byte strobes;
- a set of offsets that read as zero and ignore writes.

No offset ever signals a bus error. Read data is registered, so it appears on the cycle after the access phase.

Top module: `coh_ctl_regs`

## Requirements
- R1: After the synchronous active-low reset, the enable bit and the power status word are 0. `prdata` reads 0 and `inv_pulse` is low.
- R2: The enable register at word offset 0x00 takes `pwdata[0]` when `pstrb[0]` is set. A read of it returns the bit in bit 0, with bits [31:1] zero.
- R3: The configuration word at 0x04 reads as a mask of CPU_COUNT ones in bits [7:4], OR-ed with CPU_COUNT-1 in bits [1:0]; all other bits are zero. Writes to it are ignored. CPU_COUNT is restricted to the range 1 to 4, with a default of 1; any other value stops elaboration.
- R4: The power status word decodes at 0x08. Bits [1:0] of the address are ignored, so any byte address from 0x08 to 0x0B selects it. Strobe bit k updates byte k (bits 8k+7..8k) from `pwdata`, and bytes whose strobe is clear keep their value.
- R5: Offset 0x0C reads as zero, and a write to it changes no register. The same write drives `inv_pulse` high for exactly one cycle, the cycle after the access phase.
- R6: Offsets 0x40, 0x44, 0x50, 0x54 and every other undecoded word offset read as zero. Writes to them change no register.
- R7: `pready` is always high and `pslverr` is always low, for every offset and direction.
- R8: A read during the access phase (`psel` and `penable` high, `pwrite` low) loads `prdata` at that clock edge. `prdata` then holds its value until the next read access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| psel | input | 1 | Bank selected |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address within the window |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte-lane write strobes |
| prdata | output | 32 | Registered read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never an error |
| inv_pulse | output | 1 | One-cycle pulse after a write to 0x0C |

## Verification
The bench writes a distinct pattern to every one of the 64 word offsets and reads each one back. After every write it also re-reads the enable and power words, so a decoder that aliased an ignored offset onto a live register would be caught corrupting it. All 16 strobe masks are tried at every byte address from 0x08 to 0x0B. This exposes a design that ignores the strobes, one that decodes only the aligned address, and one that wipes the unselected lanes. The invalidate pulse is sampled in the cycle after each write and in the cycle after that. A pulse that stretches, or one that fires on a neighbouring offset, therefore shows up, and so does a `prdata` that changes on writes instead of holding.

// File: rtl/coh_ctl_regs.sv
module coh_ctl_regs #(
  parameter int unsigned CPU_COUNT = 1,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  input  logic [3:0]        pstrb,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              inv_pulse
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned LANES = 4;
  localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_CFG  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_PWR  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_INV  = IDX_W'(3);
  localparam logic [31:0] CFG_WORD =
    32'((((1 << CPU_COUNT) - 1) << 4) | (CPU_COUNT - 1));

  if (CPU_COUNT < 1 || CPU_COUNT > 4) begin : g_bad_count
    $error("coh_ctl_regs: CPU_COUNT must lie in 1..4");
  end

  logic [IDX_W-1:0] idx;
  logic             acc, wr_acc, rd_acc;
  logic             ctrl_q;
  logic [31:0]      pwr_q;
  logic [31:0]      rd_mux;
  logic [31:0]      rdata_q;
  logic             inv_q;

  assign idx    = paddr[ADDR_W-1:2];
  assign acc    = psel & penable;
  assign wr_acc = acc & pwrite;
  assign rd_acc = acc & ~pwrite;

  assign pready    = 1'b1;
  assign pslverr   = 1'b0;
  assign prdata    = rdata_q;
  assign inv_pulse = inv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= 1'b0;
      inv_q  <= 1'b0;
    end else begin
      inv_q <= wr_acc && (idx == IDX_INV);
      if (wr_acc && idx == IDX_CTRL && pstrb[0]) ctrl_q <= pwdata[0];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        pwr_q[8*k +: 8] <= 8'h00;
      else if (wr_acc && idx == IDX_PWR && pstrb[k])
        pwr_q[8*k +: 8] <= pwdata[8*k +: 8];
    end
  end

  always_comb begin
    case (idx)
      IDX_CTRL: rd_mux = {31'b0, ctrl_q};
      IDX_CFG:  rd_mux = CFG_WORD;
      IDX_PWR:  rd_mux = pwr_q;
      default:  rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= 32'h0;
    else if (rd_acc) rdata_q <= rd_mux;
  end

  assert_ctrl_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && idx == IDX_CTRL) |=> (prdata[31:1] == 31'b0));

  assert_cfg_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && idx == IDX_CFG) |=> (prdata == CFG_WORD));

  assert_lane0_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && idx == IDX_PWR && !pstrb[0]) |=> $stable(pwr_q[7:0]));

  assert_lane3_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && idx == IDX_PWR && !pstrb[3]) |=> $stable(pwr_q[31:24]));

  assert_inv_no_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && idx == IDX_INV) |=> ($stable(pwr_q) && $stable(ctrl_q) && inv_pulse));

  assert_inv_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_pulse) |-> $past(wr_acc && idx == IDX_INV));

  assert_other_no_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && idx > IDX_INV) |=> ($stable(pwr_q) && $stable(ctrl_q) && !inv_pulse));

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(prdata));
endmodule

// File: tb/test_coh_ctl_regs.sv
module test_coh_ctl_regs;
  localparam int unsigned N = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = 8'h0;
  logic [31:0] pwdata = 32'h0;
  logic [3:0]  pstrb = 4'h0;
  logic [31:0] prdata;
  logic        pready, pslverr, inv_pulse;

  int checks = 0, fails = 0;
  bit done = 0;

  logic        m_ctrl = 1'b0;
  logic [31:0] m_pwr = 32'h0;
  logic [31:0] cfg_exp;

  always #5 clk = ~clk;

  coh_ctl_regs #(.CPU_COUNT(N)) i_coh_ctl_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .inv_pulse(inv_pulse));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int idx);
    case (idx)
      0: return {31'b0, m_ctrl};
      1: return cfg_exp;
      2: return m_pwr;
      default: return 32'h0;
    endcase
  endfunction

  task automatic xfer(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] s, output logic pulse, output logic [31:0] rd);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
    @(negedge clk);
    penable = 1;
    check(pready === 1'b1 && pslverr === 1'b0, "R7", {30'b0, pready, pslverr}, 32'h2);
    @(negedge clk);
    psel = 0; penable = 0;
    pulse = inv_pulse;
    rd = prdata;
  endtask

  task automatic wr_word(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    logic p, p2;
    logic [31:0] r;
    int idx;
    idx = int'(a[7:2]);
    xfer(1'b1, a, d, s, p, r);
    check(p === (idx == 3), "R5 pulse after write", {31'b0, p}, {31'b0, idx == 3});
    @(negedge clk);
    p2 = inv_pulse;
    check(p2 === 1'b0, "R5 pulse width", {31'b0, p2}, 32'h0);
    check(prdata === r, "R8 hold across write", prdata, r);
    if (idx == 0 && s[0]) m_ctrl = d[0];
    if (idx == 2) for (int k = 0; k < 4; k++) if (s[k]) m_pwr[8*k +: 8] = d[8*k +: 8];
  endtask

  task automatic rd_word(input logic [7:0] a, input string req);
    logic p;
    logic [31:0] r, e;
    xfer(1'b0, a, 32'h0, 4'h0, p, r);
    e = exp_read(int'(a[7:2]));
    check(r === e, req, r, e);
  endtask

  initial begin
    cfg_exp = (((32'd1 << N) - 32'd1) << 4) | (N - 1);
    repeat (3) @(negedge clk);
    check(prdata === 32'h0 && inv_pulse === 1'b0, "R1 reset outputs", prdata, 32'h0);
    rst_n = 1;
    rd_word(8'h00, "R1 ctrl after reset");
    rd_word(8'h08, "R1 power after reset");
    rd_word(8'h04, "R3 config value");

    wr_word(8'h00, 32'hFFFF_FFFF, 4'hF);
    rd_word(8'h00, "R2 ctrl set, upper bits zero");
    wr_word(8'h00, 32'h0000_0000, 4'hE);
    rd_word(8'h00, "R2 ctrl kept without strobe 0");
    wr_word(8'h00, 32'hFFFF_FFFE, 4'hF);
    rd_word(8'h00, "R2 ctrl cleared");

    for (int idx = 0; idx < 64; idx++) begin
      logic [31:0] pat;
      pat = 32'h5A3C_9600 ^ (idx * 32'h0101_0101) ^ 32'h1;
      wr_word(8'(idx * 4 + (idx % 4)), pat, 4'hF);
      rd_word(8'(idx * 4), (idx == 1) ? "R3 config ignores write" :
                           (idx == 3) ? "R5 invalidate reads zero" :
                           (idx > 3)  ? "R6 ignored offset reads zero" : "R2/R4 readback");
      rd_word(8'h00, "R6 ctrl untouched by sweep");
      rd_word(8'h08, "R6 power untouched by sweep");
    end

    for (int off = 0; off < 4; off++)
      for (int s = 0; s < 16; s++) begin
        wr_word(8'(8 + off), 32'h1122_3344 * (s + 1) + off, 4'(s));
        rd_word(8'h0B - 8'(off), "R4 lane strobes");
      end

    rd_word(8'h04, "R8 read loads config");
    wr_word(8'h40, 32'hFFFF_FFFF, 4'hF);
    wr_word(8'h0C, 32'hFFFF_FFFF, 4'hF);
    check(prdata === cfg_exp, "R8 prdata held", prdata, cfg_exp);
    rd_word(8'h44, "R6 filter end reads zero");
    rd_word(8'h54, "R6 access control reads zero");

    wr_word(8'h08, 32'hDEAD_BEEF, 4'hF);
    wr_word(8'h00, 32'h1, 4'h1);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    m_ctrl = 0; m_pwr = 0;
    check(prdata === 32'h0, "R1 prdata after reset", prdata, 32'h0);
    rd_word(8'h00, "R1 ctrl after mid reset");
    rd_word(8'h08, "R1 power after mid reset");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule